// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read Timing

This block is an 18-bit first-in first-out buffer. A write clock loads it and a separate read clock drains it. The depth is a parameter. Write and read pointers are binary counters with one wrap bit. Each pointer crosses into the other clock domain as a Gray code through a chain of synchronizing flops. The write side works out the occupancy, the full indication and the half-full indication. The read side works out the empty indication and the output-ready indication. The occupancy is also brought out so that a separate offset and threshold block can compute its own flags.

The read timing is picked while master reset is held low, and it stays in force until the next master reset.
- In standard timing, a stored word is moved to the output register only by an explicit read.
- In fall-through timing, the first word that lands in an empty buffer is presented at the output without a read request. Each later word is presented only after a read request.

A partial reset empties the buffer but keeps the selected timing. A retransmit request moves the read pointer back to location zero so that the stored words can be read again. When the output enable is inactive, the output port carries a fixed idle value.

Top module: `ffx_dual_clock_fifo`

## Requirements
- R1: The level of `fwft_sel` sampled on `rclk` edges while `mrs_n` is low selects the timing: 0 gives standard, 1 gives fall-through. The selection then holds, whatever `fwft_sel` does, until the next master reset.
- R2: In standard timing, `dout` changes only after a `rclk` edge with `ren_n` low while the buffer holds data. The output register then takes the oldest stored word.
- R3: In fall-through timing, the first word written into an empty buffer appears on `dout` with `ren_n` held high. Each later word appears only after a `rclk` edge with `ren_n` low.
- R4: `rd_stat` is 1 when there is nothing to read: in standard timing this means the buffer is empty, and in fall-through timing it means no valid word is on the output. `wr_stat` is 1 when DEPTH words are stored.
- R5: A write while `wr_stat` is 1 and a read while the buffer is empty are both ignored. Neither one moves a pointer or changes stored data.
- R6: `half_full` is 1 exactly when the write-side occupancy is greater than DEPTH/2.
- R7: After master reset, `rd_stat` is 1, `wr_stat` is 0, `half_full` is 0 and `wr_fill` is 0.
- R8: A partial reset (`prs_n` low) empties the buffer, which gives `rd_stat` 1 and `wr_fill` 0. It keeps the timing selected at the last master reset.
- R9: `rt_n` low on a `rclk` edge returns the read pointer to location zero. Subsequent reads then return the stored words again, starting from the first word written since reset.
- R10: While `oe_n` is 1, `dout` equals the parameter IDLE_VAL (default 0). While `oe_n` is 0, `dout` shows the output register.
- R11: Words are read out in the order they were written, with no loss or duplication, up to a full buffer of DEPTH words.
- R12: `wr_fill` gives the number of stored words as seen in the write domain. It rises by one on each accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Master reset, active low, synchronous in both domains |
| prs_n | input | 1 | Partial reset, active low, keeps the timing selection |
| fwft_sel | input | 1 | Timing select, sampled during master reset |
| wen_n | input | 1 | Write enable, active low |
| din | input | WIDTH (18) | Write data |
| ren_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Retransmit request, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | WIDTH (18) | Read data, or IDLE_VAL when disabled |
| rd_stat | output | 1 | Nothing-to-read indication (empty / not output-ready) |
| wr_stat | output | 1 | Cannot-accept indication (full / not input-ready) |
| half_full | output | 1 | Occupancy above DEPTH/2 |
| wr_fill | output | $clog2(DEPTH)+1 | Write-domain occupancy for the threshold block |

## Verification
The embedded properties take for granted that both resets stay low across several edges of each clock. They also take for granted that the timing selection changes only under master reset. Both are needed because every pointer and status flop resets synchronously. The retransmit properties assume that no writes are in flight when the rewind happens, and that fewer than DEPTH words have been written since the last reset. Together these keep the multi-bit Gray jump safe for the write side to sample. The directed stimulus holds each reset for four read periods. It issues retransmit only after pushes have settled through the synchronizers, and it never wraps the write pointer before rewinding.

// File: rtl/ffx_pkg.sv
`timescale 1ns/1ps
package ffx_pkg;

   typedef enum logic {
      TM_STANDARD = 1'b0,
      TM_FALLTHRU = 1'b1
   } ffx_mode_e;

   function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/ffx_sync.sv
`timescale 1ns/1ps
module ffx_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ffx_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ffx_wr_ctl.sv
`timescale 1ns/1ps
module ffx_wr_ctl #(
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH),
   parameter int PW    = AW + 1
) (
   input  logic          wclk,
   input  logic          rst,
   input  logic          wen_n,
   input  logic [PW-1:0] rgray_s,
   output logic [PW-1:0] wbin,
   output logic [PW-1:0] wgray,
   output logic          wr_fire,
   output logic          full,
   output logic          half,
   output logic [PW-1:0] fill
);

   logic [PW-1:0] wbin_q, wgray_q, rbin_s, wbin_nx;

   assign rbin_s  = PW'(ffx_pkg::gray_to_bin(32'(rgray_s)));
   assign fill    = wbin_q - rbin_s;
   assign full    = (fill == PW'(DEPTH));
   assign half    = (fill > PW'(DEPTH / 2));
   assign wr_fire = !wen_n && !full;
   assign wbin_nx = wbin_q + 1'b1;

   always_ff @(posedge wclk) begin
      if (rst) begin
         wbin_q  <= '0;
         wgray_q <= '0;
      end else if (wr_fire) begin
         wbin_q  <= wbin_nx;
         wgray_q <= PW'(ffx_pkg::bin_to_gray(32'(wbin_nx)));
      end
   end

   assign wbin  = wbin_q;
   assign wgray = wgray_q;

   AST_FILL_BOUND: assert property (@(posedge wclk) disable iff (rst)
      fill <= PW'(DEPTH));                                             // R5
   AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (rst)
      (full && !wen_n) |=> $stable(wbin_q));                           // R5
   AST_FULL_HAS_HALF: assert property (@(posedge wclk) disable iff (rst)
      full |-> half);                                                  // R6

endmodule

// File: rtl/ffx_rd_ctl.sv
`timescale 1ns/1ps
module ffx_rd_ctl
   import ffx_pkg::*;
#(
   parameter int WIDTH = 18,
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH),
   parameter int PW    = AW + 1
) (
   input  logic             rclk,
   input  logic             rst,
   input  ffx_mode_e        mode,
   input  logic             ren_n,
   input  logic             rt_n,
   input  logic [PW-1:0]    wgray_s,
   input  logic [WIDTH-1:0] rd_word,
   output logic [PW-1:0]    rbin,
   output logic [PW-1:0]    rgray,
   output logic [WIDTH-1:0] dout_q,
   output logic             rd_stat
);

   logic [PW-1:0] rbin_q, rgray_q, wbin_s, rbin_nx;
   logic          ram_empty, ov_q, take;

   assign wbin_s    = PW'(gray_to_bin(32'(wgray_s)));
   assign ram_empty = (rbin_q == wbin_s);
   assign rbin_nx   = rbin_q + 1'b1;

   always_comb begin
      if (mode == TM_STANDARD) take = !ren_n && !ram_empty;
      else                     take = !ram_empty && (!ov_q || !ren_n);
   end

   always_ff @(posedge rclk) begin
      if (rst) begin
         rbin_q  <= '0;
         rgray_q <= '0;
         ov_q    <= 1'b0;
         dout_q  <= '0;
      end else if (!rt_n) begin
         rbin_q  <= '0;
         rgray_q <= '0;
         ov_q    <= 1'b0;
      end else if (take) begin
         dout_q  <= rd_word;
         rbin_q  <= rbin_nx;
         rgray_q <= PW'(bin_to_gray(32'(rbin_nx)));
         ov_q    <= 1'b1;
      end else if (!ren_n) begin
         ov_q    <= 1'b0;
      end
   end

   assign rbin    = rbin_q;
   assign rgray   = rgray_q;
   assign rd_stat = (mode == TM_STANDARD) ? ram_empty : !ov_q;

   AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rst)
      (ram_empty && rt_n) |=> $stable(rbin_q));                        // R5
   AST_RT_REWIND: assert property (@(posedge rclk) disable iff (rst)
      !rt_n |=> (rbin_q == '0));                                       // R9
   AST_STD_HOLD: assert property (@(posedge rclk) disable iff (rst)
      (mode == TM_STANDARD && ren_n && rt_n) |=> $stable(dout_q));     // R2
   AST_FT_HOLD: assert property (@(posedge rclk) disable iff (rst)
      (mode == TM_FALLTHRU && ov_q && ren_n && rt_n)
         |=> (ov_q && $stable(dout_q)));                               // R3

endmodule

// File: rtl/ffx_dual_clock_fifo.sv
`timescale 1ns/1ps
module ffx_dual_clock_fifo
   import ffx_pkg::*;
#(
   parameter int               WIDTH       = 18,
   parameter int               DEPTH       = 256,
   parameter int               SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE_VAL    = '0,
   localparam int              AW          = $clog2(DEPTH),
   localparam int              PW          = AW + 1
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             mrs_n,
   input  logic             prs_n,
   input  logic             fwft_sel,
   input  logic             wen_n,
   input  logic [WIDTH-1:0] din,
   input  logic             ren_n,
   input  logic             rt_n,
   input  logic             oe_n,
   output logic [WIDTH-1:0] dout,
   output logic             rd_stat,
   output logic             wr_stat,
   output logic             half_full,
   output logic [PW-1:0]    wr_fill
);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ffx_dual_clock_fifo: DEPTH must be a power of two, at least 4");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ffx_dual_clock_fifo: WIDTH must be positive");
   end

   logic             any_rst;
   ffx_mode_e        mode_q;
   logic [PW-1:0]    wbin, wgray, rbin, rgray, wgray_s, rgray_s;
   logic             wr_fire;
   logic [WIDTH-1:0] mem [DEPTH];
   logic [WIDTH-1:0] rd_word, dout_q;

   assign any_rst = !mrs_n || !prs_n;

   always_ff @(posedge rclk) begin
      if (!mrs_n) mode_q <= fwft_sel ? TM_FALLTHRU : TM_STANDARD;
   end

   always_ff @(posedge wclk) begin
      if (wr_fire) mem[wbin[AW-1:0]] <= din;
   end
   assign rd_word = mem[rbin[AW-1:0]];

   ffx_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
      .wclk(wclk), .rst(any_rst), .wen_n(wen_n), .rgray_s(rgray_s),
      .wbin(wbin), .wgray(wgray), .wr_fire(wr_fire), .full(wr_stat),
      .half(half_full), .fill(wr_fill)
   );

   ffx_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wclk), .rst(any_rst), .d(rgray), .q(rgray_s)
   );

   ffx_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rclk), .rst(any_rst), .d(wgray), .q(wgray_s)
   );

   ffx_rd_ctl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
      .rclk(rclk), .rst(any_rst), .mode(mode_q), .ren_n(ren_n), .rt_n(rt_n),
      .wgray_s(wgray_s), .rd_word(rd_word), .rbin(rbin), .rgray(rgray),
      .dout_q(dout_q), .rd_stat(rd_stat)
   );

   assign dout = oe_n ? IDLE_VAL : dout_q;

   AST_RESET_EMPTY: assert property (@(posedge rclk)
      !mrs_n |=> rd_stat);                                             // R7

endmodule

// File: tb/sim_ffx_dual_clock_fifo.sv
`timescale 1ns/1ps
module sim_ffx_dual_clock_fifo;

   localparam int DEPTH = 256;
   localparam int PW    = $clog2(DEPTH) + 1;

   logic          wclk = 1'b0, rclk = 1'b0;
   logic          mrs_n = 1'b0, prs_n = 1'b1, fwft_sel = 1'b0;
   logic          wen_n = 1'b1, ren_n = 1'b1, rt_n = 1'b1, oe_n = 1'b0;
   logic [17:0]   din = '0;
   logic [17:0]   dout;
   logic          rd_stat, wr_stat, half_full;
   logic [PW-1:0] wr_fill;

   int vectors = 0;
   int miscompares = 0;

   always #4 wclk = ~wclk;   // 125 MHz
   always #6 rclk = ~rclk;

   ffx_dual_clock_fifo #(.DEPTH(DEPTH)) u0 (
      .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .prs_n(prs_n),
      .fwft_sel(fwft_sel), .wen_n(wen_n), .din(din), .ren_n(ren_n),
      .rt_n(rt_n), .oe_n(oe_n), .dout(dout), .rd_stat(rd_stat),
      .wr_stat(wr_stat), .half_full(half_full), .wr_fill(wr_fill)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic mreset(input logic ft);
      @(negedge rclk);
      fwft_sel = ft; mrs_n = 1'b0;
      repeat (4) @(negedge rclk);
      mrs_n = 1'b1; fwft_sel = ~ft;
      repeat (2) @(negedge rclk);
   endtask

   task automatic preset(input logic ft);
      @(negedge rclk);
      fwft_sel = ft; prs_n = 1'b0;
      repeat (4) @(negedge rclk);
      prs_n = 1'b1;
      repeat (2) @(negedge rclk);
   endtask

   task automatic push(input logic [17:0] v);
      @(negedge wclk);
      wen_n = 1'b0; din = v;
      @(negedge wclk);
      wen_n = 1'b1;
   endtask

   task automatic pop();
      @(negedge rclk);
      ren_n = 1'b0;
      @(negedge rclk);
      ren_n = 1'b1;
   endtask

   task automatic settle();
      repeat (6) @(negedge rclk);
   endtask

   task automatic t_reset();
      mreset(1'b0);
      chk("R7 rd_stat", 32'(rd_stat), 1);
      chk("R7 wr_stat", 32'(wr_stat), 0);
      chk("R7 half_full", 32'(half_full), 0);
      chk("R7 wr_fill", 32'(wr_fill), 0);
   endtask

   task automatic t_standard();
      mreset(1'b0);
      push(18'h00A1); push(18'h00B2); push(18'h00C3);
      settle();
      chk("R2 no read no data", 32'(dout), 0);
      chk("R4 std not empty", 32'(rd_stat), 0);
      chk("R12 fill three", 32'(wr_fill), 3);
      pop(); chk("R2 first read", 32'(dout), 32'h00A1);
      pop(); chk("R11 second read", 32'(dout), 32'h00B2);
      pop(); chk("R11 third read", 32'(dout), 32'h00C3);
      chk("R4 std empty", 32'(rd_stat), 1);
      pop(); chk("R5 read while empty", 32'(dout), 32'h00C3);
      chk("R5 still empty", 32'(rd_stat), 1);
   endtask

   task automatic t_fallthru();
      mreset(1'b1);
      chk("R4 ft not ready", 32'(rd_stat), 1);
      push(18'h1111);
      settle();
      chk("R3 first word falls through", 32'(dout), 32'h1111);
      chk("R4 ft ready", 32'(rd_stat), 0);
      push(18'h2222);
      settle();
      chk("R3 later word waits", 32'(dout), 32'h1111);
      pop(); chk("R3 advance on read", 32'(dout), 32'h2222);
      pop(); chk("R4 ft drained", 32'(rd_stat), 1);
   endtask

   task automatic t_mode_hold();
      mreset(1'b1);
      preset(1'b0);
      chk("R8 prs empties", 32'(rd_stat), 1);
      chk("R8 prs fill", 32'(wr_fill), 0);
      push(18'h0777);
      settle();
      chk("R8 mode kept after prs", 32'(dout), 32'h0777);
      mreset(1'b0);
      push(18'h1234);
      settle();
      chk("R1 std after new mrs", 32'(dout), 0);
      chk("R1 std flag", 32'(rd_stat), 0);
      pop(); chk("R1 read in std", 32'(dout), 32'h1234);
   endtask

   task automatic t_fill();
      mreset(1'b0);
      for (int i = 0; i < DEPTH / 2; i++) push(18'(i + 'h100));
      chk("R12 fill half", 32'(wr_fill), DEPTH / 2);
      chk("R6 half at exactly half", 32'(half_full), 0);
      push(18'(DEPTH / 2 + 'h100));
      chk("R6 half above", 32'(half_full), 1);
      for (int i = DEPTH / 2 + 1; i < DEPTH; i++) push(18'(i + 'h100));
      chk("R4 full", 32'(wr_stat), 1);
      push(18'h3FFFF);
      chk("R5 write while full", 32'(wr_fill), DEPTH);
      settle();
      begin
         int bad = 0;
         for (int i = 0; i < DEPTH; i++) begin
            pop();
            if (dout !== 18'(i + 'h100)) bad++;
         end
         chk("R11 order over full buffer", 32'(bad), 0);
      end
      chk("R5 no extra word", 32'(rd_stat), 1);
      settle();
      chk("R6 half cleared", 32'(half_full), 0);
      chk("R12 fill drained", 32'(wr_fill), 0);
   endtask

   task automatic t_retransmit();
      mreset(1'b0);
      push(18'h0051); push(18'h0052); push(18'h0053);
      settle();
      pop(); pop(); pop();
      chk("R9 drained", 32'(rd_stat), 1);
      @(negedge rclk); rt_n = 1'b0;
      @(negedge rclk); rt_n = 1'b1;
      settle();
      chk("R9 data again", 32'(rd_stat), 0);
      pop(); chk("R9 first again", 32'(dout), 32'h0051);
      pop(); chk("R9 second again", 32'(dout), 32'h0052);
      chk("R12 fill after rewind", 32'(wr_fill), 2);
   endtask

   task automatic t_oe();
      @(negedge rclk); oe_n = 1'b1;
      @(negedge rclk);
      chk("R10 idle value", 32'(dout), 0);
      oe_n = 1'b0;
      @(negedge rclk);
      chk("R10 enabled", 32'(dout), 32'h0052);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      repeat (150000) @(posedge wclk);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_standard();
      t_fallthru();
      t_mode_hold();
      t_fill();
      t_retransmit();
      t_oe();
      summary();
      $finish;
   end

endmodule